// File: doc/BRIEF.md
# Translation Descriptor Access and Dirty Repair Unit

This unit sits at the last step of a translation walk. It takes the Block or Page descriptor that the walker fetched, together with the kind of access (read or write), the translation stage (1 or 2) and two enable bits. One enable turns on hardware upkeep of the accessed bit. The other turns on hardware upkeep of dirty state. The walker may also report that it has already found a permission fault or a memory-type alignment fault for the same descriptor. From these inputs the unit gives one of three results. It reports a fault. It passes the descriptor through unchanged. Or it repairs the descriptor in memory with an atomic sequence, made of a locked read, a compare against the walked value and a write. The repair sets the accessed bit, makes the descriptor writable, or does both in a single write.

If the value in memory no longer matches the walked value, another agent has changed the descriptor. In that case the unit drops the lock, takes the fresh value as its new working copy and judges it again from the start. When an operation finishes, the unit raises `done` for one cycle and presents the fault flag, the fault code and the final descriptor.

Descriptor layout used by the unit: bit 10 is the accessed bit (1 means accessed). Bit 7 is the write-control bit. At stage 1, a value of 1 forbids writes. At stage 2, a value of 0 forbids writes. Bit 51 is the dirty-tracking enable (DBM) of the descriptor. Fault codes: 0 none, 1 accessed-bit fault, 2 permission fault, 3 alignment fault.

Top module: `desc_ad_update`

## Requirements
- R1: While reset is low and right after it, `done`, `mem_req` and `mem_lock` are 0.
- R2: A descriptor with bit 10 = 0, when accessed-bit upkeep is disabled, ends with fault code 1. There is no memory traffic, and `desc_out` equals the walked descriptor.
- R3: A descriptor with bit 10 = 0, when accessed-bit upkeep is enabled and no other fault applies, is written back with bit 10 = 1 through one locked write. It ends with no fault, and `desc_out` shows bit 10 = 1.
- R4: An alignment fault reported by the walker gives code 3. Otherwise, a permission fault reported by the walker gives code 2. In both cases the descriptor is never updated, even when bit 10 = 0.
- R5: A stage 1 write to a descriptor with bit 7 = 1 and bit 51 = 1 clears bit 7 when both enables are 1. It also sets bit 10 if that bit is 0, in the same single write, and ends with no fault.
- R6: A stage 2 write to a descriptor with bit 7 = 0 and bit 51 = 1 sets bit 7 to 1 when both enables are 1, and ends with no fault.
- R7: A write to a write-forbidding descriptor ends with fault code 2 and no memory write in each of these cases: bit 51 = 0, dirty upkeep disabled, or accessed-bit upkeep disabled. Dirty upkeep needs accessed-bit upkeep. This permission fault takes priority over an accessed-bit fault.
- R8: A read never changes bit 7. A read of a descriptor with bit 10 = 1, and a write to an already writable descriptor with bit 10 = 1, both pass with no memory traffic.
- R9: If the locked read returns a value that differs from the working copy, no write follows. The unit judges the returned value again, and that value decides the result.
- R10: A memory write is only issued with `mem_lock` high. `mem_req`, `mem_we` and `mem_addr` stay steady until `mem_ack`.
- R11: `done` is a single-cycle pulse. `fault` is 1 exactly when `fault_code` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one operation (sampled while idle) |
| walk_addr | input | AW | Memory address of the descriptor |
| walk_desc | input | 64 | Descriptor value seen by the walk |
| is_write | input | 1 | 1 = write access, 0 = read |
| stage2 | input | 1 | 1 = stage 2 descriptor, 0 = stage 1 |
| ha_en | input | 1 | Hardware accessed-bit upkeep enable |
| hd_en | input | 1 | Hardware dirty upkeep enable |
| perm_fault_in | input | 1 | Walker already found a permission fault |
| align_fault_in | input | 1 | Walker found a memory-type alignment fault |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation ended in a fault |
| fault_code | output | 2 | 0 none, 1 accessed-bit, 2 permission, 3 alignment |
| desc_out | output | 64 | Final descriptor value |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_lock | output | 1 | Atomic lock over read, compare and write |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` on a read |

## Verification
A wrong verdict appears at `done`, in the fault code and in `desc_out`, a handful of cycles after `start`. A missing or unwanted repair appears in the bench memory's write count and in its final word. A sequencer that loses the lock, changes the request before acknowledge, or writes after a failed compare breaks the memory-port properties in the very cycle of the fault. A compare that wrongly matches shows up as a stale overwrite in the race tests.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int DESC_W  = 64;
  localparam int AF_POS  = 10;
  localparam int WP_POS  = 7;
  localparam int DBM_POS = 51;

  typedef logic [DESC_W-1:0] desc_t;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_ACCESS = 2'd1,
    FC_PERM   = 2'd2,
    FC_ALIGN  = 2'd3
  } fcode_t;

  typedef struct packed {
    logic is_write;
    logic stage2;
    logic ha;
    logic hd;
    logic perm_in;
    logic align_in;
  } acc_ctl_t;

  typedef struct packed {
    fcode_t code;
    logic   upd;
    desc_t  next;
  } verdict_t;

  // stage 1: bit set forbids writes; stage 2: bit clear forbids writes
  function automatic logic write_blocked(desc_t d, logic s2);
    return s2 ? ~d[WP_POS] : d[WP_POS];
  endfunction

  function automatic desc_t grant_write(desc_t d, logic s2);
    desc_t r;
    r = d;
    r[WP_POS] = s2;
    return r;
  endfunction

  function automatic verdict_t judge(desc_t d, acc_ctl_t c);
    verdict_t v;
    logic blocked;
    logic dirty_ok;
    blocked  = c.is_write & write_blocked(d, c.stage2);
    dirty_ok = c.ha & c.hd & d[DBM_POS];
    v.code = FC_NONE;
    v.upd  = 1'b0;
    v.next = d;
    if (c.align_in) begin
      v.code = FC_ALIGN;
    end else if (c.perm_in) begin
      v.code = FC_PERM;
    end else if (blocked && !dirty_ok) begin
      v.code = FC_PERM;
    end else if (!d[AF_POS] && !c.ha) begin
      v.code = FC_ACCESS;
    end else begin
      v.next[AF_POS] = 1'b1;
      if (blocked) v.next = grant_write(v.next, c.stage2);
      v.upd = (v.next != d);
    end
    return v;
  endfunction
endpackage

// File: rtl/desc_eval.sv
module desc_eval
  import desc_pkg::*;
(
  input  desc_t    cur,
  input  acc_ctl_t ctl,
  output verdict_t v
);
  always_comb v = judge(cur, ctl);
endmodule

// File: rtl/desc_rmw_seq.sv
module desc_rmw_seq
  import desc_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] walk_addr,
  input  desc_t         walk_desc,
  input  acc_ctl_t      ctl_in,
  input  verdict_t      v,
  output desc_t         cur,
  output acc_ctl_t      ctl_q,
  output logic          done,
  output fcode_t        res_code,
  output desc_t         res_desc,
  output logic          mem_req,
  output logic          mem_lock,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output desc_t         mem_wdata,
  input  logic          mem_ack,
  input  desc_t         mem_rdata,
  output logic          cmp_hit,
  output logic          cmp_miss
);
  typedef enum logic [2:0] {S_IDLE, S_JUDGE, S_LRD, S_CMP, S_WR, S_DONE} st_t;
  st_t           st;
  logic [AW-1:0] addr_q;
  desc_t         new_q;
  desc_t         rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      ctl_q    <= '0;
      addr_q   <= '0;
      new_q    <= '0;
      rd_q     <= '0;
      res_code <= FC_NONE;
      res_desc <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          cur    <= walk_desc;
          ctl_q  <= ctl_in;
          addr_q <= walk_addr;
          st     <= S_JUDGE;
        end
        S_JUDGE: if (v.upd) begin
          new_q <= v.next;
          st    <= S_LRD;
        end else begin
          res_code <= v.code;
          res_desc <= cur;
          st       <= S_DONE;
        end
        S_LRD: if (mem_ack) begin
          rd_q <= mem_rdata;
          st   <= S_CMP;
        end
        S_CMP: if (cmp_hit) begin
          st <= S_WR;
        end else begin
          cur <= rd_q;
          st  <= S_JUDGE;
        end
        S_WR: if (mem_ack) begin
          res_code <= FC_NONE;
          res_desc <= new_q;
          st       <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmp_hit   = (st == S_CMP) && (rd_q == cur);
  assign cmp_miss  = (st == S_CMP) && (rd_q != cur);
  assign done      = (st == S_DONE);
  assign mem_req   = (st == S_LRD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_lock  = (st == S_LRD) || cmp_hit || (st == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
endmodule

// File: rtl/desc_ad_update.sv
module desc_ad_update
  import desc_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] walk_addr,
  input  logic [63:0]   walk_desc,
  input  logic          is_write,
  input  logic          stage2,
  input  logic          ha_en,
  input  logic          hd_en,
  input  logic          perm_fault_in,
  input  logic          align_fault_in,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_code,
  output logic [63:0]   desc_out,
  output logic          mem_req,
  output logic          mem_lock,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata
);
  acc_ctl_t ctl_in;
  acc_ctl_t ctl_q;
  desc_t    cur;
  verdict_t v;
  fcode_t   res_code;
  desc_t    res_desc;
  logic     cmp_hit;
  logic     cmp_miss;
  logic     wr_fire;

  assign ctl_in = '{is_write: is_write, stage2: stage2, ha: ha_en, hd: hd_en,
                    perm_in: perm_fault_in, align_in: align_fault_in};

  desc_eval u_eval (
    .cur (cur),
    .ctl (ctl_q),
    .v   (v)
  );

  desc_rmw_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .walk_addr (walk_addr),
    .walk_desc (walk_desc),
    .ctl_in    (ctl_in),
    .v         (v),
    .cur       (cur),
    .ctl_q     (ctl_q),
    .done      (done),
    .res_code  (res_code),
    .res_desc  (res_desc),
    .mem_req   (mem_req),
    .mem_lock  (mem_lock),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .cmp_hit   (cmp_hit),
    .cmp_miss  (cmp_miss)
  );

  assign wr_fire    = mem_req & mem_we & mem_ack;
  assign fault_code = res_code;
  assign fault      = (res_code != FC_NONE);
  assign desc_out   = res_desc;
endmodule

// File: rtl/desc_ad_update_chk.sv
module desc_ad_update_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          fault,
  input logic [1:0]    fault_code,
  input logic          out_af,
  input logic          mem_req,
  input logic          mem_lock,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          cmp_miss,
  input logic          wr_fire
);
  a_r10_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == (fault_code != 2'd0)));

  a_r3_pass_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> out_af);

  a_r9_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_miss |=> !(mem_req && mem_we));

  a_r1_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !mem_req);
endmodule

bind desc_ad_update desc_ad_update_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .fault      (fault),
  .fault_code (fault_code),
  .out_af     (desc_out[10]),
  .mem_req    (mem_req),
  .mem_lock   (mem_lock),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .cmp_miss   (cmp_miss),
  .wr_fire    (wr_fire)
);

// File: tb/test_desc_ad_update.sv
module test_desc_ad_update;
  localparam int AW = 40;

  typedef struct packed {
    logic [63:0] d;
    logic wr, s2, ha, hd, pf, al;
    logic [1:0]  code;
    logic [63:0] exp;
    logic [3:0]  nw;
  } vec_t;

  // bit 10 accessed, bit 7 write control, bit 51 dirty-tracking enable
  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{64'h0000_0000_1234_5003, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 64'h0000_0000_1234_5003, 4'd0}, // R2
    '{64'h0000_0000_1234_5003, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 64'h0000_0000_1234_5403, 4'd1}, // R3
    '{64'h0000_0000_1234_5003, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd2, 64'h0000_0000_1234_5003, 4'd0}, // R4
    '{64'h0000_0000_1234_5003, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 2'd3, 64'h0000_0000_1234_5003, 4'd0}, // R4
    '{64'h0008_0000_1234_5483, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 64'h0008_0000_1234_5403, 4'd1}, // R5
    '{64'h0008_0000_1234_5083, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 64'h0008_0000_1234_5403, 4'd1}, // R5
    '{64'h0008_0000_1234_5403, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 2'd0, 64'h0008_0000_1234_5483, 4'd1}, // R6
    '{64'h0000_0000_1234_5483, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 2'd2, 64'h0000_0000_1234_5483, 4'd0}, // R7
    '{64'h0008_0000_1234_5483, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd2, 64'h0008_0000_1234_5483, 4'd0}, // R7
    '{64'h0008_0000_1234_5483, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd2, 64'h0008_0000_1234_5483, 4'd0}, // R7
    '{64'h0008_0000_1234_5083, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2, 64'h0008_0000_1234_5083, 4'd0}, // R7
    '{64'h0000_0000_1234_5403, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 2'd2, 64'h0000_0000_1234_5403, 4'd0}, // R7
    '{64'h0008_0000_1234_5483, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 64'h0008_0000_1234_5483, 4'd0}, // R8
    '{64'h0000_0000_1234_5483, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 64'h0000_0000_1234_5483, 4'd0}, // R8
    '{64'h0008_0000_1234_5003, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 2'd0, 64'h0008_0000_1234_5403, 4'd1}  // R8
  };
  localparam string VREQ [NV] = '{"R2","R3","R4","R4","R5","R5","R6","R7","R7","R7","R7","R7","R8","R8","R8"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] walk_addr = '0;
  logic [63:0]   walk_desc = '0;
  logic          is_write = 1'b0, stage2 = 1'b0, ha_en = 1'b0, hd_en = 1'b0;
  logic          perm_fault_in = 1'b0, align_fault_in = 1'b0;
  logic          done, fault;
  logic [1:0]    fault_code;
  logic [63:0]   desc_out;
  logic          mem_req, mem_lock, mem_we;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [63:0]   mem_rdata = '0;

  logic [63:0]   mem_word = '0;
  logic [63:0]   pre_val = '0;
  logic          pre_go = 1'b0;
  int            nwr = 0;
  int            unlocked_wr = 0;
  int            unstable_req = 0;
  int            tests = 0;
  int            fails = 0;

  always #4 clk = ~clk;

  desc_ad_update #(.AW(AW)) i_desc_ad_update (.*);

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (pre_go) mem_word <= pre_val;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem_word <= mem_wdata;
        nwr <= nwr + 1;
      end else begin
        mem_rdata <= mem_word;
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req && mem_we && !mem_lock) unlocked_wr <= unlocked_wr + 1;
  end

  logic          prev_pend = 1'b0;
  logic          prev_we = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (prev_pend && (!mem_req || mem_we != prev_we || mem_addr != prev_addr))
      unstable_req <= unstable_req + 1;
    prev_pend <= mem_req && !mem_ack;
    prev_we   <= mem_we;
    prev_addr <= mem_addr;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [63:0] d, logic [63:0] minit,
                        logic wr, logic s2, logic ha, logic hd, logic pf, logic al,
                        logic [1:0] code, logic [63:0] exp, int nw_exp, logic [63:0] mem_exp);
    int w0;
    bit seen;
    @(negedge clk);
    w0 = nwr;
    walk_desc = d; walk_addr = 40'h12_3456_7000;
    is_write = wr; stage2 = s2; ha_en = ha; hd_en = hd;
    perm_fault_in = pf; align_fault_in = al;
    pre_val = minit; pre_go = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; pre_go = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    check({req, " done"}, {63'd0, seen}, 64'd1);
    check({req, " code"}, {62'd0, fault_code}, {62'd0, code});
    check({req, " R11 fault flag"}, {63'd0, fault}, {63'd0, code != 2'd0});
    check({req, " desc"}, desc_out, exp);
    check({req, " writes"}, 64'(nwr - w0), 64'(nw_exp));
    check({req, " memory"}, mem_word, mem_exp);
    @(negedge clk);
    check("R11 done pulse", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 req", {63'd0, mem_req}, 64'd0);
    check("R1 lock", {63'd0, mem_lock}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after", {63'd0, done}, 64'd0);
    check("R1 req after", {63'd0, mem_req}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      run_op(VREQ[k], VT[k].d, VT[k].d, VT[k].wr, VT[k].s2, VT[k].ha, VT[k].hd,
             VT[k].pf, VT[k].al, VT[k].code, VT[k].exp, int'(VT[k].nw), VT[k].exp);
    end

    // R9: another agent already set bit 10; no write, pass with fresh value
    run_op("R9 race pass", 64'h0000_0000_1234_5003, 64'h0000_0000_1234_5403,
           1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0,
           64'h0000_0000_1234_5403, 0, 64'h0000_0000_1234_5403);
    // R9: fresh value is write-protected without DBM -> permission fault
    run_op("R9 race fault", 64'h0000_0000_1234_5003, 64'h0000_0000_1234_5083,
           1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2,
           64'h0000_0000_1234_5083, 0, 64'h0000_0000_1234_5083);
    // R9: fresh value still needs a repair -> repaired from the fresh value
    run_op("R9 race repair", 64'h0008_0000_1234_5003, 64'h0008_0000_1234_5083,
           1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0,
           64'h0008_0000_1234_5403, 1, 64'h0008_0000_1234_5403);

    check("R10 unlocked writes", 64'(unlocked_wr), 64'd0);
    check("R10 request stability", 64'(unstable_req), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule